// File: doc/BRIEF.md
# Assertion Debug Event Controller

This block sits between a bank of hard-wired assertion checkers and the run-stop debug logic of a chip. Each checker drives one fire line. The lines are split into equal groups, and a small configuration register switches whole groups on or off. Each line is fixed at build time as either error class or warning class. A firing line in an enabled group sets a sticky bit in a status chain. If that line is error class, it also raises a stop request that works like a hardware breakpoint.

The stop request stays high until the debugger acknowledges it or clears the block. The status chain is read out one bit per clock through a scan-style serial port. While the chain is shifting, capture of new violations is paused. A clear input empties the status and drops the stop request.

The block has no streaming data path. Every pin is a plain level-sensitive control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `asrt_evt_ctl`

## Requirements
- R1: After reset, the group enable output is all zero, the stop request is low and every status bit reads 0.
- R2: A cycle with `cfg_wr_i` high loads `cfg_data_i` into the group enable register. The new value appears on `grp_en_o` after that clock edge. Without a write the register holds.
- R3: Fire line i belongs to group i / PER_GROUP. A fire in a group whose enable bit is 0 sets no status bit and causes no stop.
- R4: A fire on an enabled error-class line (ERR_MASK bit = 1; the default 16'h5555 makes even lines errors) raises `stop_req_o` after the clock edge that samples it. This holds when no clear, acknowledge or shift is active.
- R5: A fire on an enabled warning-class line (ERR_MASK bit = 0) sets its status bit and never raises `stop_req_o`.
- R6: Status bits are sticky. A set bit stays set until it is cleared or shifted. Repeated fires of a flagged line leave the single bit at 1.
- R7: `stop_req_o` stays high until `stop_ack_i` or `clear_i`. An acknowledge drops it after the next edge and leaves the status bits untouched.
- R8: `clear_i` zeroes all status bits and the stop request after the next edge. It takes priority over shifting and over capture.
- R9: With `shift_en_i` high, each edge moves the chain one place toward `scan_out_o`, and `scan_in_i` enters at the far end. `scan_out_o` shows status bit 0, so N shifts deliver bits 0 through N-1 in that order. The first bit shifted in ends up in bit 0.
- R10: While `shift_en_i` is high, fire lines neither set status bits nor raise a stop.
- R11: When an acknowledge and a new enabled error fire fall in the same cycle, the acknowledge wins. The stop request is low after the edge, but the error's status bit is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fire_i | input | NUM_GROUPS*PER_GROUP | One fire line per assertion checker |
| cfg_wr_i | input | 1 | Write strobe for the group enable register |
| cfg_data_i | input | NUM_GROUPS | New group enable value |
| grp_en_o | output | NUM_GROUPS | Current group enable register |
| clear_i | input | 1 | Clear all status bits and the stop request |
| stop_ack_i | input | 1 | Acknowledge of a granted stop |
| stop_req_o | output | 1 | Stop request to the run-stop logic |
| shift_en_i | input | 1 | Shift the status chain one place |
| scan_in_i | input | 1 | Serial input at the far end of the chain |
| scan_out_o | output | 1 | Status bit 0, the serial output |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a stop acknowledge and a fresh error fire. The bench drives both in one cycle and expects the request low afterwards, while a serial read still shows the error's status bit. The second pair is a clear and a shift with fires present. The bench raises all three together and expects an empty chain and no stop. A further case fires every line during a shift alone; the bench judges it by the stop pin and by a full serial readout that must come back empty.

// File: rtl/asrt_evt_pkg.sv
package asrt_evt_pkg;

  // Operation applied to the status chain on a clock edge.
  typedef enum logic [1:0] {
    OP_CAPTURE = 2'd0,
    OP_SHIFT   = 2'd1,
    OP_CLEAR   = 2'd2
  } chain_op_e;

  // Group that owns a given fire line.
  function automatic int grp_of(input int idx, input int per_grp);
    return idx / per_grp;
  endfunction

endpackage

// File: rtl/asrt_grp_cfg.sv
module asrt_grp_cfg #(
  parameter int NUM_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [NUM_GROUPS-1:0] data_i,
  output logic [NUM_GROUPS-1:0] en_q
);

  // All groups start disabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (wr_i) en_q <= data_i;
  end

endmodule

// File: rtl/asrt_fire_qual.sv
module asrt_fire_qual
  import asrt_evt_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int PER_GROUP  = 4,
  localparam int NUM_LINES = NUM_GROUPS * PER_GROUP,
  parameter logic [NUM_LINES-1:0] ERR_MASK = 16'h5555
) (
  input  logic [NUM_GROUPS-1:0] grp_en_i,
  input  logic [NUM_LINES-1:0]  fire_i,
  output logic [NUM_LINES-1:0]  hit_o,
  output logic                  err_hit_o
);

  logic [NUM_LINES-1:0] line_en;

  // Spread each group enable over the lines it owns.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign line_en[i] = grp_en_i[grp_of(i, PER_GROUP)];
  end

  assign hit_o     = fire_i & line_en;
  assign err_hit_o = |(hit_o & ERR_MASK);

endmodule

// File: rtl/asrt_status_chain.sv
module asrt_status_chain
  import asrt_evt_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  chain_op_e            op_i,
  input  logic                 scan_in_i,
  input  logic [NUM_LINES-1:0] hit_i,
  output logic [NUM_LINES-1:0] status_q,
  output logic                 scan_out_o
);

  logic [NUM_LINES-1:0] status_d;

  always_comb begin
    unique case (op_i)
      OP_CLEAR: status_d = '0;
      OP_SHIFT: status_d = {scan_in_i, status_q[NUM_LINES-1:1]};
      default:  status_d = status_q | hit_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign scan_out_o = status_q[0];

endmodule

// File: rtl/asrt_stop_ctl.sv
module asrt_stop_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic ack_i,
  input  logic shift_i,
  input  logic err_hit_i,
  output logic stop_q
);

  // Release beats a new request; shifting pauses new requests.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        stop_q <= 1'b0;
    else if (clear_i || ack_i)         stop_q <= 1'b0;
    else if (err_hit_i && !shift_i)    stop_q <= 1'b1;
  end

endmodule

// File: rtl/asrt_evt_ctl.sv
module asrt_evt_ctl
  import asrt_evt_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int PER_GROUP  = 4,
  localparam int NUM_LINES = NUM_GROUPS * PER_GROUP,
  parameter logic [NUM_LINES-1:0] ERR_MASK = 16'h5555
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  fire_i,
  input  logic                  cfg_wr_i,
  input  logic [NUM_GROUPS-1:0] cfg_data_i,
  output logic [NUM_GROUPS-1:0] grp_en_o,
  input  logic                  clear_i,
  input  logic                  stop_ack_i,
  output logic                  stop_req_o,
  input  logic                  shift_en_i,
  input  logic                  scan_in_i,
  output logic                  scan_out_o
);

  logic [NUM_LINES-1:0] hit;
  logic                 err_hit;
  logic [NUM_LINES-1:0] status_q;
  chain_op_e            op;

  always_comb begin
    if (clear_i)         op = OP_CLEAR;
    else if (shift_en_i) op = OP_SHIFT;
    else                 op = OP_CAPTURE;
  end

  asrt_grp_cfg #(.NUM_GROUPS(NUM_GROUPS)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (cfg_wr_i),
    .data_i (cfg_data_i),
    .en_q   (grp_en_o)
  );

  asrt_fire_qual #(
    .NUM_GROUPS (NUM_GROUPS),
    .PER_GROUP  (PER_GROUP),
    .ERR_MASK   (ERR_MASK)
  ) u_qual (
    .grp_en_i  (grp_en_o),
    .fire_i    (fire_i),
    .hit_o     (hit),
    .err_hit_o (err_hit)
  );

  asrt_status_chain #(.NUM_LINES(NUM_LINES)) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op),
    .scan_in_i  (scan_in_i),
    .hit_i      (hit),
    .status_q   (status_q),
    .scan_out_o (scan_out_o)
  );

  asrt_stop_ctl u_stop (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear_i),
    .ack_i     (stop_ack_i),
    .shift_i   (shift_en_i),
    .err_hit_i (err_hit),
    .stop_q    (stop_req_o)
  );

endmodule

// File: rtl/asrt_evt_ctl_chk.sv
module asrt_evt_ctl_chk #(
  parameter int NUM_GROUPS = 4,
  parameter int PER_GROUP  = 4,
  localparam int NUM_LINES = NUM_GROUPS * PER_GROUP,
  parameter logic [NUM_LINES-1:0] ERR_MASK = 16'h5555
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_LINES-1:0]  fire_i,
  input logic                  cfg_wr_i,
  input logic [NUM_GROUPS-1:0] grp_en_o,
  input logic                  clear_i,
  input logic                  stop_ack_i,
  input logic                  stop_req_o,
  input logic                  shift_en_i,
  input logic                  scan_in_i,
  input logic [NUM_LINES-1:0]  status_q
);

  logic [NUM_LINES-1:0] grp_mask;
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_m
    assign grp_mask[i] = grp_en_o[i / PER_GROUP];
  end

  logic err_fire;
  assign err_fire = |(fire_i & grp_mask & ERR_MASK);

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_i |=> $stable(grp_en_o));

  assert_err_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_fire && !clear_i && !stop_ack_i && !shift_en_i) |=> stop_req_o);

  assert_rise_needs_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req_o) |-> $past(err_fire));

  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !shift_en_i) |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_stop_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req_o && !clear_i && !stop_ack_i) |=> stop_req_o);

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!stop_req_o && status_q == '0));

  assert_shift_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en_i && !clear_i) |=>
      (status_q[NUM_LINES-1] == $past(scan_in_i)) &&
      (status_q[NUM_LINES-2:0] == $past(status_q[NUM_LINES-1:1])));

  assert_shift_no_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en_i && !stop_req_o) |=> !stop_req_o);

  assert_ack_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ack_i |=> !stop_req_o);

endmodule

bind asrt_evt_ctl asrt_evt_ctl_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .PER_GROUP  (PER_GROUP),
  .ERR_MASK   (ERR_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fire_i     (fire_i),
  .cfg_wr_i   (cfg_wr_i),
  .grp_en_o   (grp_en_o),
  .clear_i    (clear_i),
  .stop_ack_i (stop_ack_i),
  .stop_req_o (stop_req_o),
  .shift_en_i (shift_en_i),
  .scan_in_i  (scan_in_i),
  .status_q   (status_q)
);

// File: tb/test_asrt_evt_ctl.sv
`timescale 1ns/1ps
module test_asrt_evt_ctl;

  localparam int G = 4;
  localparam int P = 4;
  localparam int N = G * P;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] fire = '0;
  logic         cfg_wr = 1'b0;
  logic [G-1:0] cfg_data = '0;
  logic [G-1:0] grp_en;
  logic         clear = 1'b0;
  logic         ack = 1'b0;
  logic         stop_req;
  logic         shift_en = 1'b0;
  logic         scan_in = 1'b0;
  logic         scan_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  asrt_evt_ctl #(.NUM_GROUPS(G), .PER_GROUP(P), .ERR_MASK(16'h5555)) i_asrt_evt_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_i     (fire),
    .cfg_wr_i   (cfg_wr),
    .cfg_data_i (cfg_data),
    .grp_en_o   (grp_en),
    .clear_i    (clear),
    .stop_ack_i (ack),
    .stop_req_o (stop_req),
    .shift_en_i (shift_en),
    .scan_in_i  (scan_in),
    .scan_out_o (scan_out)
  );

  task automatic step(); @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_fire(input logic [N-1:0] v);
    fire = v; step(); fire = '0;
  endtask

  task automatic write_cfg(input logic [G-1:0] v);
    cfg_data = v; cfg_wr = 1'b1; step(); cfg_wr = 1'b0;
  endtask

  task automatic do_clear();
    clear = 1'b1; step(); clear = 1'b0;
  endtask

  // Read the full chain serially (scan_in held 0), bit 0 first.
  task automatic read_chain(input string req, input logic [N-1:0] exp);
    logic [N-1:0] got;
    for (int k = 0; k < N; k++) begin
      got[k] = scan_out;
      shift_en = 1'b1; step(); shift_en = 1'b0;
    end
    chk(req, 32'(got), 32'(exp));
  endtask

  task automatic t_reset();
    chk("R1 grp_en", 32'(grp_en), 0);
    chk("R1 stop", 32'(stop_req), 0);
    read_chain("R1 status", '0);
  endtask

  task automatic t_cfg_mixed();
    write_cfg(4'b1010);
    chk("R2 grp_en", 32'(grp_en), 32'hA);
    step();
    chk("R2 hold", 32'(grp_en), 32'hA);
    pulse_fire('1);
    chk("R4 stop from enabled error", 32'(stop_req), 1);
    read_chain("R3 only groups 1,3 logged", 16'hF0F0);
    do_clear();
  endtask

  task automatic t_disabled();
    pulse_fire(16'h0001);
    chk("R3 disabled group no stop", 32'(stop_req), 0);
    read_chain("R3 disabled group no status", '0);
  endtask

  task automatic t_warning();
    write_cfg(4'hF);
    pulse_fire(16'h0002);
    step(); step();
    chk("R5 warning no stop", 32'(stop_req), 0);
    read_chain("R5 warning logged", 16'h0002);
  endtask

  task automatic t_hold_ack();
    pulse_fire(16'h0004);
    chk("R4 stop raised", 32'(stop_req), 1);
    repeat (5) step();
    chk("R7 stop held", 32'(stop_req), 1);
    ack = 1'b1; step(); ack = 1'b0;
    chk("R7 ack drops stop", 32'(stop_req), 0);
    read_chain("R7 ack keeps status", 16'h0004);
  endtask

  task automatic t_sticky();
    pulse_fire(16'h0200);
    step();
    pulse_fire(16'h0200);
    pulse_fire(16'h0200);
    read_chain("R6 repeated fires one bit", 16'h0200);
  endtask

  task automatic t_clear_prio();
    pulse_fire(16'h0009);
    chk("R4 stop before clear", 32'(stop_req), 1);
    clear = 1'b1; shift_en = 1'b1; scan_in = 1'b1; fire = 16'h0100;
    step();
    clear = 1'b0; shift_en = 1'b0; scan_in = 1'b0; fire = '0;
    chk("R8 clear drops stop", 32'(stop_req), 0);
    read_chain("R8 clear beats shift and capture", '0);
  endtask

  task automatic t_shift_order();
    logic [N-1:0] pat = 16'hC35A;
    pulse_fire(16'h002A);
    read_chain("R9 bit order", 16'h002A);
    for (int k = 0; k < N; k++) begin
      scan_in = pat[k]; shift_en = 1'b1; step();
    end
    shift_en = 1'b0; scan_in = 1'b0;
    read_chain("R9 scan_in loads chain", pat);
  endtask

  task automatic t_shift_ignore();
    shift_en = 1'b1; fire = '1; step();
    shift_en = 1'b0; fire = '0;
    chk("R10 no stop while shifting", 32'(stop_req), 0);
    read_chain("R10 no capture while shifting", '0);
  endtask

  task automatic t_collide();
    fire = 16'h0001; ack = 1'b1; step();
    fire = '0; ack = 1'b0;
    chk("R11 ack wins stop", 32'(stop_req), 0);
    read_chain("R11 status still set", 16'h0001);
    pulse_fire(16'h0010);
    chk("R11 stop up again", 32'(stop_req), 1);
    fire = 16'h0040; ack = 1'b1; step();
    fire = '0; ack = 1'b0;
    chk("R11 ack wins while high", 32'(stop_req), 0);
    do_clear();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_cfg_mixed();
    t_disabled();
    t_warning();
    t_hold_ack();
    t_sticky();
    t_clear_prio();
    t_shift_order();
    t_shift_ignore();
    t_collide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule